// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block gathers a small set of external interrupt lines and presents at most one of them at a time to a single processor. Each line has its own configuration word, holding a mask, an in-service flag, a 4-bit priority, a vector, a sense mode and a polarity, plus a routing word. The controller picks the best pending line that is unmasked and routed. It drives its interrupt output only when that line's priority is strictly above both the processor's task priority and the priority of every line already in service.

Software reads an acknowledge register to obtain the winning vector. That read marks the line in service. A write to the end-of-interrupt register retires the most urgent line in service. When no line qualifies, the acknowledge read returns a programmable spurious vector. A global configuration word carries a self-clearing soft-reset bit, and a read-only feature word describes the size of the block. Inputs are asynchronous and pass through a two-flop synchroniser.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every configuration word reads 0x8000_0000 (masked, all else zero), every routing word reads 0, task priority reads 15, the spurious vector reads 0xFF and `irq_o` is low.
- R2: A configuration word (word address 0x10+2·i, routing word at 0x11+2·i) has bit 31 = mask, bit 30 = in-service (read-only), bit 23 = polarity (1 = high/rising), bit 22 = sense (1 = level, 0 = edge), bits 19:16 = priority and bits VEC_W-1:0 = vector. A written mask value reads back as written.
- R3: A line whose mask is 1, or whose routing bit 0 is 0, never raises `irq_o` and is never returned by an acknowledge read.
- R4: The task priority (word 0x03, bits 3:0) admits only lines whose priority is strictly greater than it. At 15 no line is admitted.
- R5: A read of the acknowledge word (0x04) returns the vector of the highest-priority qualifying line, with ties going to the lowest index. If none qualifies, it returns the spurious vector (word 0x02).
- R6: An acknowledge read sets the winner's in-service bit. An in-service line blocks other lines of equal or lower priority, and a strictly higher line can still nest above it.
- R7: While a line is in service, writes to its configuration word change only the mask. Priority, vector, sense and polarity keep their values.
- R8: Any write to the end-of-interrupt word (0x05) clears the in-service bit of the highest-priority line in service. A read of that word returns 0 and changes nothing.
- R9: An edge-sensed line latches a pending flag on the edge selected by its polarity. The flag survives the input returning to idle, is ignored on the opposite edge, and is cleared by the acknowledge.
- R10: A level-sensed line is pending while its synchronised input sits at the active level, so it is presented again after its end-of-interrupt if the input is still active.
- R11: `irq_o` is a registered level that is low in the cycle after an acknowledge read.
- R12: Writing bit 31 of the global word (0x00) returns every configuration word, routing word, pending flag and in-service bit to its reset value one cycle later, and the bit then reads 0.
- R13: The feature word (0x01) reads (NSRC-1) in bits 26:16, 0 (last processor index) in bits 12:8 and VERSION in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | NSRC | Asynchronous interrupt lines, one per source |
| bus_sel_i | input | 1 | Register access strobe for this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the current state |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with its defaults, NSRC = 4 and VEC_W = 8. Four lines are enough to place a three-way priority tie and a two-deep nest under one threshold. With eight vector bits, any random vector, including one equal to the spurious value, can be told apart from the spurious value only through the bench's own arbitration model. The random phase drives all four lines in level mode with random masks, routes, polarities, priorities and thresholds. Edge sensing, nesting and in-service write protection are reached by directed sequences.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int ADDR_W     = 6;
  localparam int PRI_W      = 4;
  localparam int VP_MASK_B  = 31;
  localparam int VP_ACT_B   = 30;
  localparam int VP_POL_B   = 23;
  localparam int VP_SENSE_B = 22;
  localparam int VP_PRI_LSB = 16;
  localparam int GCFG_RST_B = 31;

  localparam logic [ADDR_W-1:0] A_GCFG     = 6'h00;
  localparam logic [ADDR_W-1:0] A_FEAT     = 6'h01;
  localparam logic [ADDR_W-1:0] A_SPUR     = 6'h02;
  localparam logic [ADDR_W-1:0] A_TASK     = 6'h03;
  localparam logic [ADDR_W-1:0] A_ACK      = 6'h04;
  localparam logic [ADDR_W-1:0] A_EOI      = 6'h05;
  localparam logic [ADDR_W-1:0] A_SRC_BASE = 6'h10;

  // feature word: last source index, last processor index (always 0), version
  function automatic logic [31:0] feat_word(int nsrc, logic [7:0] ver);
    return (32'(nsrc - 1) << 16) | {24'b0, ver};
  endfunction

  function automatic logic [PRI_W-1:0] pri_max(logic [PRI_W-1:0] a, logic [PRI_W-1:0] b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pic_input.sv
module pic_input (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic sense_lvl_i,
  input  logic pol_hi_i,
  input  logic clr_i,
  output logic pend_o
);
  logic [1:0] sync_q;
  logic       prev_q;
  logic       edge_q;
  logic       s;
  logic       edge_hit;

  assign s        = sync_q[1];
  assign edge_hit = pol_hi_i ? (s & ~prev_q) : (~s & prev_q);
  assign pend_o   = sense_lvl_i ? (s == pol_hi_i) : edge_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      prev_q <= s;
      edge_q <= edge_hit | (edge_q & ~clr_i);
    end
  end
endmodule

// File: rtl/pic_srcreg.sv
module pic_srcreg #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst_i,
  input  logic             wr_vp_i,
  input  logic             wr_dst_i,
  input  logic [31:0]      wdata_i,
  input  logic             act_set_i,
  input  logic             act_clr_i,
  output logic             mask_o,
  output logic             act_o,
  output logic             pol_o,
  output logic             sense_o,
  output logic [3:0]       pri_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             route_o,
  output logic [31:0]      vp_word_o
);
  import pic_pkg::*;

  logic unused_wbits;
  assign unused_wbits = ^wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o <= 1'b1; act_o <= 1'b0; pol_o <= 1'b0; sense_o <= 1'b0;
      pri_o <= '0; vec_o <= '0; route_o <= 1'b0;
    end else if (soft_rst_i) begin
      mask_o <= 1'b1; act_o <= 1'b0; pol_o <= 1'b0; sense_o <= 1'b0;
      pri_o <= '0; vec_o <= '0; route_o <= 1'b0;
    end else begin
      if (wr_vp_i) begin
        mask_o <= wdata_i[VP_MASK_B];
        if (!act_o) begin
          pol_o   <= wdata_i[VP_POL_B];
          sense_o <= wdata_i[VP_SENSE_B];
          pri_o   <= wdata_i[VP_PRI_LSB +: PRI_W];
          vec_o   <= wdata_i[VEC_W-1:0];
        end
      end
      if (wr_dst_i) route_o <= wdata_i[0];
      if (act_set_i)      act_o <= 1'b1;
      else if (act_clr_i) act_o <= 1'b0;
    end
  end

  always_comb begin
    vp_word_o = '0;
    vp_word_o[VP_MASK_B]  = mask_o;
    vp_word_o[VP_ACT_B]   = act_o;
    vp_word_o[VP_POL_B]   = pol_o;
    vp_word_o[VP_SENSE_B] = sense_o;
    vp_word_o[VP_PRI_LSB +: PRI_W] = pri_o;
    vp_word_o[VEC_W-1:0]  = vec_o;
  end
endmodule

// File: rtl/pic_arb.sv
module pic_arb #(
  parameter int NSRC  = 4,
  parameter int IDX_W = 2
) (
  input  logic [NSRC-1:0]      cand_i,
  input  logic [NSRC-1:0]      act_i,
  input  logic [NSRC-1:0][3:0] pri_i,
  input  logic [3:0]           task_i,
  output logic                 win_valid_o,
  output logic [IDX_W-1:0]     win_idx_o,
  output logic                 done_valid_o,
  output logic [IDX_W-1:0]     done_idx_o
);
  import pic_pkg::*;

  logic [3:0] act_top;
  logic [3:0] thr;
  logic [3:0] best;

  always_comb begin
    act_top      = '0;
    done_valid_o = 1'b0;
    done_idx_o   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (act_i[i] && (!done_valid_o || pri_i[i] > act_top)) begin
        done_valid_o = 1'b1;
        done_idx_o   = IDX_W'(i);
        act_top      = pri_i[i];
      end
    end
    thr         = pri_max(act_top, task_i);
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    best        = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand_i[i] && pri_i[i] > thr && (!win_valid_o || pri_i[i] > best)) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDX_W'(i);
        best        = pri_i[i];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int         NSRC    = 4,
  parameter int         VEC_W   = 8,
  parameter logic [7:0] VERSION = 8'h02
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_src_i,
  input  logic            bus_sel_i,
  input  logic            bus_wr_i,
  input  logic [5:0]      bus_addr_i,
  input  logic [31:0]     bus_wdata_i,
  output logic [31:0]     bus_rdata_o,
  output logic            irq_o
);
  import pic_pkg::*;

  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic rd_en, wr_en, ack_fire, eoi_fire;
  logic [5:0] off;
  logic [4:0] src_idx;
  logic src_hit;
  logic rst_bit_q, irq_q;
  logic [VEC_W-1:0] spur_q;
  logic [3:0] task_q;

  logic [NSRC-1:0] mask_vec, act_vec, pol_vec, sense_vec, route_vec, pend_vec, cand_vec;
  logic [NSRC-1:0][3:0] pri_vec;
  logic [NSRC-1:0][VEC_W-1:0] vec_arr;
  logic [NSRC-1:0][31:0] vp_words;

  logic win_valid, done_valid;
  logic [IDX_W-1:0] win_idx, done_idx;
  logic [VEC_W-1:0] win_vec;

  assign rd_en    = bus_sel_i & ~bus_wr_i;
  assign wr_en    = bus_sel_i & bus_wr_i;
  assign ack_fire = rd_en && (bus_addr_i == A_ACK);
  assign eoi_fire = wr_en && (bus_addr_i == A_EOI);
  assign off      = bus_addr_i - A_SRC_BASE;
  assign src_idx  = off[5:1];
  assign src_hit  = (bus_addr_i >= A_SRC_BASE) && ({26'b0, off} < 32'(2 * NSRC));

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic wr_vp, wr_dst, act_set, act_clr;
    assign wr_vp   = wr_en && src_hit && (src_idx == 5'(i)) && !bus_addr_i[0];
    assign wr_dst  = wr_en && src_hit && (src_idx == 5'(i)) &&  bus_addr_i[0];
    assign act_set = ack_fire && win_valid && (win_idx == IDX_W'(i));
    assign act_clr = eoi_fire && done_valid && (done_idx == IDX_W'(i));

    pic_srcreg #(.VEC_W(VEC_W)) reg_i (
      .clk(clk), .rst_n(rst_n), .soft_rst_i(rst_bit_q),
      .wr_vp_i(wr_vp), .wr_dst_i(wr_dst), .wdata_i(bus_wdata_i),
      .act_set_i(act_set), .act_clr_i(act_clr),
      .mask_o(mask_vec[i]), .act_o(act_vec[i]), .pol_o(pol_vec[i]),
      .sense_o(sense_vec[i]), .pri_o(pri_vec[i]), .vec_o(vec_arr[i]),
      .route_o(route_vec[i]), .vp_word_o(vp_words[i])
    );

    pic_input in_i (
      .clk(clk), .rst_n(rst_n), .raw_i(irq_src_i[i]),
      .sense_lvl_i(sense_vec[i]), .pol_hi_i(pol_vec[i]),
      .clr_i(act_set | rst_bit_q), .pend_o(pend_vec[i])
    );

    assign cand_vec[i] = pend_vec[i] & ~mask_vec[i] & route_vec[i] & ~act_vec[i];
  end

  pic_arb #(.NSRC(NSRC), .IDX_W(IDX_W)) arb_i (
    .cand_i(cand_vec), .act_i(act_vec), .pri_i(pri_vec), .task_i(task_q),
    .win_valid_o(win_valid), .win_idx_o(win_idx),
    .done_valid_o(done_valid), .done_idx_o(done_idx)
  );

  always_comb begin
    win_vec = '0;
    for (int i = 0; i < NSRC; i++)
      if (win_idx == IDX_W'(i)) win_vec = vec_arr[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_bit_q <= 1'b0;
      spur_q    <= '1;
      task_q    <= 4'hF;
      irq_q     <= 1'b0;
    end else begin
      if (rst_bit_q) rst_bit_q <= 1'b0;
      else if (wr_en && bus_addr_i == A_GCFG) rst_bit_q <= bus_wdata_i[GCFG_RST_B];
      if (wr_en && bus_addr_i == A_SPUR) spur_q <= bus_wdata_i[VEC_W-1:0];
      if (wr_en && bus_addr_i == A_TASK) task_q <= bus_wdata_i[3:0];
      irq_q <= win_valid && !ack_fire && !rst_bit_q;
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    bus_rdata_o = '0;
    if (src_hit) begin
      for (int i = 0; i < NSRC; i++)
        if (src_idx == 5'(i))
          bus_rdata_o = bus_addr_i[0] ? {31'b0, route_vec[i]} : vp_words[i];
    end else begin
      case (bus_addr_i)
        A_GCFG: bus_rdata_o[GCFG_RST_B] = rst_bit_q;
        A_FEAT: bus_rdata_o = feat_word(NSRC, VERSION);
        A_SPUR: bus_rdata_o[VEC_W-1:0] = spur_q;
        A_TASK: bus_rdata_o[3:0] = task_q;
        A_ACK:  bus_rdata_o[VEC_W-1:0] = win_valid ? win_vec : spur_q;
        default: bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
  parameter int NSRC  = 4,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_o,
  input logic             ack_fire,
  input logic             eoi_fire,
  input logic             win_valid,
  input logic             rst_bit_q,
  input logic [NSRC-1:0]  act_vec,
  input logic [NSRC-1:0]  mask_vec,
  input logic [3:0]       task_q,
  input logic [VEC_W-1:0] spur_q,
  input logic [31:0]      bus_rdata_o
);
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> !irq_o); // R11
  AST_TASK_MAX_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (task_q == 4'hF) |-> !win_valid); // R4
  AST_SPUR_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !win_valid) |-> (bus_rdata_o[VEC_W-1:0] == spur_q)); // R5
  AST_ACT_NEEDS_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoi_fire && !rst_bit_q) |=> ((act_vec & $past(act_vec)) == $past(act_vec))); // R6
  AST_ACK_SETS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && win_valid && !rst_bit_q) |=> ($countones(act_vec) == $countones($past(act_vec)) + 1)); // R6
  AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_fire && act_vec != '0 && !rst_bit_q) |=> ($countones(act_vec) + 1 == $countones($past(act_vec)))); // R8
  AST_SOFT_RESET_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_bit_q |=> (!rst_bit_q && (&mask_vec) && act_vec == '0)); // R12
endmodule

bind prio_irq_ctrl pic_chk #(.NSRC(NSRC), .VEC_W(VEC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .ack_fire(ack_fire), .eoi_fire(eoi_fire),
  .win_valid(win_valid), .rst_bit_q(rst_bit_q), .act_vec(act_vec), .mask_vec(mask_vec),
  .task_q(task_q), .spur_q(spur_q), .bus_rdata_o(bus_rdata_o)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  localparam int NS = 4;
  localparam logic [5:0] GCFG = 6'h00, FEAT = 6'h01, SPUR = 6'h02, TASK = 6'h03, ACK = 6'h04, EOI = 6'h05;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] irq_src = '0;
  logic sel = 1'b0, wr = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;
  int n_chk = 0, n_fail = 0;
  logic [31:0] q;

  always #10 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_src_i(irq_src), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [5:0] vp(int i);  return 6'(16 + 2 * i); endfunction
  function automatic logic [5:0] dst(int i); return 6'(17 + 2 * i); endfunction
  function automatic logic [31:0] vpw(logic m, logic pol, logic lvl, logic [3:0] p, logic [7:0] v);
    return {m, 1'b0, 6'b0, pol, lvl, 2'b0, p, 8'b0, v};
  endfunction

  task automatic bus(input logic w, input logic [5:0] a, input logic [31:0] d, output logic [31:0] r);
    @(negedge clk); sel = 1'b1; wr = w; addr = a; wdata = d;
    #2 r = rdata;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask
  task automatic wreg(input logic [5:0] a, input logic [31:0] d);
    logic [31:0] dummy; bus(1'b1, a, d, dummy);
  endtask
  task automatic rreg(input logic [5:0] a, output logic [31:0] r);
    bus(1'b0, a, 32'h0, r);
  endtask
  task automatic wait_cyc(input int n); repeat (n) @(negedge clk); endtask
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  initial begin
    #(20 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [3:0] rp[NS];
    logic [7:0] rv[NS];
    logic rm[NS], rr[NS], rpol[NS], rin[NS];
    logic [3:0] rt;
    int best;
    q = $urandom(32'd2024);
    wait_cyc(3); rst_n = 1'b1; wait_cyc(2);

    // reset state
    rreg(vp(0), q);  chk("R1 vp0 reset", q, 32'h8000_0000);
    rreg(vp(3), q);  chk("R1 vp3 reset", q, 32'h8000_0000);
    rreg(dst(0), q); chk("R1 dst0 reset", q, 0);
    rreg(TASK, q);   chk("R1 task reset", q, 15);
    rreg(SPUR, q);   chk("R1 spur reset", q, 32'hFF);
    chk("R1 irq low", {31'b0, irq}, 0);
    rreg(ACK, q);    chk("R5 spurious at reset", q, 32'hFF);
    rreg(FEAT, q);   chk("R13 feature word", q, 32'h0003_0002);

    // level source 0
    wreg(vp(0), vpw(0, 1, 1, 5, 8'h21)); wreg(dst(0), 1); wreg(TASK, 0);
    irq_src[0] = 1'b1; wait_cyc(4);
    chk("R10 level raises irq", {31'b0, irq}, 1);
    rreg(vp(0), q); chk("R2 vp0 readback", q, 32'h00C5_0021);
    rreg(ACK, q);   chk("R5 ack vec", q, 32'h21);
    chk("R11 irq drops after ack", {31'b0, irq}, 0);
    rreg(vp(0), q); chk("R6 activity set", q, 32'h40C5_0021);
    wreg(vp(0), vpw(0, 0, 0, 9, 8'h33));
    rreg(vp(0), q); chk("R7 fields locked", q, 32'h40C5_0021);
    wreg(vp(0), 32'h8000_0000);
    rreg(vp(0), q); chk("R7 mask writable", q, 32'hC0C5_0021);
    wreg(vp(0), vpw(0, 1, 1, 5, 8'h21));
    rreg(EOI, q);   chk("R8 eoi read zero", q, 0);
    rreg(vp(0), q); chk("R8 eoi read no effect", q, 32'h40C5_0021);
    wreg(EOI, 0); wait_cyc(3);
    chk("R10 re-presented after eoi", {31'b0, irq}, 1);
    rreg(vp(0), q); chk("R8 activity cleared", q, 32'h00C5_0021);
    rreg(ACK, q);   chk("R10 second ack", q, 32'h21);
    wreg(EOI, 0); irq_src[0] = 1'b0; wait_cyc(4);
    chk("R10 inactive level no irq", {31'b0, irq}, 0);

    // edge source 1
    wreg(vp(1), vpw(0, 1, 0, 3, 8'h31)); wreg(dst(1), 1);
    irq_src[1] = 1'b1; wait_cyc(2); irq_src[1] = 1'b0; wait_cyc(4);
    chk("R9 edge latched", {31'b0, irq}, 1);
    rreg(ACK, q); chk("R9 edge ack", q, 32'h31);
    wreg(EOI, 0);
    rreg(ACK, q); chk("R9 pending cleared by ack", q, 32'hFF);
    wreg(vp(1), vpw(0, 0, 0, 3, 8'h31));
    irq_src[1] = 1'b1; wait_cyc(4);
    rreg(ACK, q); chk("R9 rising ignored when falling selected", q, 32'hFF);
    irq_src[1] = 1'b0; wait_cyc(4);
    chk("R9 falling edge raises irq", {31'b0, irq}, 1);
    rreg(ACK, q); chk("R9 falling edge ack", q, 32'h31);
    wreg(EOI, 0); wreg(vp(1), vpw(1, 0, 0, 3, 8'h31));

    // priority, ties, nesting
    wreg(vp(2), vpw(0, 1, 1, 5, 8'h41)); wreg(dst(2), 1);
    wreg(vp(3), vpw(0, 1, 1, 7, 8'h51)); wreg(dst(3), 1);
    irq_src = 4'b1101; wait_cyc(4);
    rreg(ACK, q); chk("R5 highest priority wins", q, 32'h51);
    rreg(ACK, q); chk("R6 in-service blocks lower", q, 32'hFF);
    wreg(EOI, 0); wreg(vp(3), vpw(1, 1, 1, 7, 8'h51));
    rreg(ACK, q); chk("R5 tie to lowest index", q, 32'h21);
    rreg(ACK, q); chk("R6 equal priority blocked", q, 32'hFF);
    wreg(vp(3), vpw(0, 1, 1, 7, 8'h51)); wait_cyc(3);
    chk("R6 higher nests irq", {31'b0, irq}, 1);
    rreg(ACK, q); chk("R6 nested ack", q, 32'h51);
    wreg(EOI, 0);
    rreg(vp(3), q); chk("R8 highest in-service retired", q, 32'h00C7_0051);
    rreg(vp(0), q); chk("R8 lower still in service", q, 32'h40C5_0021);
    wreg(EOI, 0);
    rreg(vp(0), q); chk("R8 second eoi retires", q, 32'h00C5_0021);

    // task threshold
    wreg(TASK, 7); rreg(ACK, q); chk("R4 equal to task blocked", q, 32'hFF);
    wreg(TASK, 6); rreg(ACK, q); chk("R4 above task admitted", q, 32'h51);
    wreg(EOI, 0); wreg(vp(3), vpw(1, 1, 1, 7, 8'h51));
    wreg(TASK, 5); rreg(ACK, q); chk("R4 strict threshold", q, 32'hFF);
    wreg(TASK, 4); rreg(ACK, q); chk("R4 below threshold passes", q, 32'h21);
    wreg(EOI, 0); wreg(vp(3), vpw(0, 1, 1, 7, 8'h51));
    wreg(TASK, 15); wait_cyc(2);
    chk("R4 task 15 no irq", {31'b0, irq}, 0);
    rreg(ACK, q); chk("R4 task 15 spurious", q, 32'hFF);
    wreg(SPUR, 32'hA5); rreg(ACK, q); chk("R5 programmed spurious", q, 32'hA5);
    wreg(SPUR, 32'hFF);

    // routing and mask
    wreg(vp(3), vpw(1, 1, 1, 7, 8'h51));
    wreg(TASK, 0); wreg(dst(0), 0); wreg(dst(2), 0); wait_cyc(3);
    chk("R3 unrouted no irq", {31'b0, irq}, 0);
    rreg(ACK, q);    chk("R3 unrouted not acked", q, 32'hFF);
    rreg(dst(2), q); chk("R3 dst readback", q, 0);
    wreg(vp(0), vpw(1, 1, 1, 5, 8'h21)); wreg(vp(2), vpw(1, 1, 1, 5, 8'h41));
    wreg(dst(0), 1); wreg(dst(2), 1); wait_cyc(3);
    chk("R3 masked no irq", {31'b0, irq}, 0);
    rreg(ACK, q); chk("R3 masked not acked", q, 32'hFF);

    // soft reset bit
    wreg(vp(0), vpw(0, 1, 1, 5, 8'h21));
    rreg(ACK, q); chk("R5 ack before soft reset", q, 32'h21);
    wreg(GCFG, 32'h8000_0000);
    rreg(GCFG, q);   chk("R12 reset bit self clears", q, 0);
    rreg(vp(0), q);  chk("R12 vp0 defaulted", q, 32'h8000_0000);
    rreg(dst(0), q); chk("R12 dst0 defaulted", q, 0);
    wreg(vp(0), vpw(0, 1, 1, 5, 8'h21)); wreg(dst(0), 1);
    rreg(ACK, q); chk("R12 in-service cleared", q, 32'h21);
    wreg(EOI, 0);

    // constrained random, level mode on all lines
    for (int it = 0; it < 40; it++) begin
      for (int s = 0; s < NS; s++) begin
        rp[s] = 4'($urandom % 16); rv[s] = 8'($urandom % 256);
        rm[s] = ($urandom % 4) == 0; rr[s] = ($urandom % 4) != 0;
        rpol[s] = 1'($urandom % 2); rin[s] = 1'($urandom % 2);
        wreg(vp(s), vpw(rm[s], rpol[s], 1'b1, rp[s], rv[s]));
        wreg(dst(s), {31'b0, rr[s]});
        irq_src[s] = rin[s];
      end
      rt = 4'($urandom % 16);
      wreg(TASK, {28'b0, rt}); wait_cyc(4);
      best = -1;
      for (int s = 0; s < NS; s++)
        if (!rm[s] && rr[s] && rin[s] == rpol[s] && rp[s] > rt && (best < 0 || rp[s] > rp[best]))
          best = s;
      chk("R3/R4 random irq level", {31'b0, irq}, (best >= 0) ? 1 : 0);
      rreg(ACK, q);
      chk("R5 random ack", q, (best >= 0) ? {24'b0, rv[best]} : 32'hFF);
      if (best >= 0) wreg(EOI, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule